// File: doc/BRIEF.md
# Three-Instruction Boundary Scan Test Port

This block is the test access port of a programmable device. A four-wire serial link (clock, mode select, serial data in, serial data out) steps a sixteen-state controller. That controller moves data through an instruction register and through one of two data paths: a one-bit bypass stage, or a boundary register that sits between the core logic and the pads. There is no asynchronous test reset pin. The controller is returned to its reset state only through the mode-select line.

Three instructions are decoded. The first is external test, which hands pad output values and output enables to the boundary register's holding latches. The second is sample/preload, which captures live values and lets holding latches be loaded while the pads still follow the core. The third is bypass. Any other opcode behaves as bypass. Several such ports can be chained serial-out to serial-in on a board. The number of device pins is a parameter, and each pin contributes three boundary cells.

Top module: `tap_scan_ctrl`

## Requirements
- R1: Five or more consecutive clock rising edges with `tms` high place the controller in its reset state from any state. In that state the instruction latch is set to all ones (bypass) on the falling edge, so the pads follow the core.
- R2: In Capture-IR the instruction shift register loads the binary value 001, with the upper bits zero. This value is shifted out on `tdo`, least significant bit first.
- R3: The opcodes are 3 bits wide: 000 selects external test, 001 selects sample/preload, and 111 selects bypass. Every other opcode (010, 011, 100, 101, 110) selects the bypass path.
- R4: The bypass stage loads 0 in Capture-DR and delays `tdi` by one shift cycle on its way to `tdo`.
- R5: The boundary register holds 3*NUM_PINS bits, shifted least significant bit first, with `tdi` entering at the top bit. For pin i, bit 3i captures `pad_in[i]`, bit 3i+1 captures `core_out[i]`, and bit 3i+2 captures `core_oe[i]`. Capture happens in Capture-DR under both external test and sample/preload.
- R6: While the current instruction is not external test, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`.
- R7: While the current instruction is external test, `pad_out[i]` is holding-latch bit 3i+1 and `pad_oe[i]` is holding-latch bit 3i+2. Values preloaded under sample/preload drive the pads from the moment external test takes effect.
- R8: `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR. Both `tdo` and `tdo_oe` change on the falling edge of `tck`.
- R9: The instruction latch changes only on a falling edge in Update-IR or in the reset state.
- R10: The boundary holding latches change only on a falling edge in Update-DR while external test or sample/preload is selected. An instruction scan leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | High while `tdo` should be driven |
| pad_in | input | NUM_PINS | Values seen at the pads |
| core_out | input | NUM_PINS | Output data from core logic |
| core_oe | input | NUM_PINS | Output enables from core logic |
| pad_out | output | NUM_PINS | Output data sent to the pad drivers |
| pad_oe | output | NUM_PINS | Output enables sent to the pad drivers |

## Verification
The assertions check the following on every cycle once the controller has reached its reset state:
- a run of five high `tms` samples forces the reset state, and that state leaves bypass in the instruction latch;
- `tdo_oe` tracks the shift states;
- both sets of holding latches stay frozen outside their update states;
- the pads follow the core under any non-external-test instruction.

Only the bench scenarios can show the serial contents: the 001 capture pattern, the one-bit bypass delay, the capture order of the boundary cells, and that every opcode picks the path of the correct length. The bench also shows that a preload survives the switch into external test.

// File: rtl/tap_pkg.sv
package tap_pkg;

   typedef enum logic [3:0] {
      ST_RESET,
      ST_IDLE,
      ST_SEL_DR,
      ST_CAP_DR,
      ST_SHF_DR,
      ST_EX1_DR,
      ST_PAU_DR,
      ST_EX2_DR,
      ST_UPD_DR,
      ST_SEL_IR,
      ST_CAP_IR,
      ST_SHF_IR,
      ST_EX1_IR,
      ST_PAU_IR,
      ST_EX2_IR,
      ST_UPD_IR
   } tap_state_e;

   localparam int unsigned CELLS_PER_PIN = 3;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e nxt;

   always_comb begin
      unique case (state)
         ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
         ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
         ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
         ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
         ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
         ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
         ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
         ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
         default:   nxt = ST_RESET;
      endcase
   end

   // No reset pin: the tms sequence alone brings the state home.
   always_ff @(posedge tck) begin
      state <= nxt;
   end

endmodule

// File: rtl/tap_instr_reg.sv
module tap_instr_reg
   import tap_pkg::*;
#(
   parameter int unsigned IR_W = 3
) (
   input  logic            tck,
   input  logic            tdi,
   input  tap_state_e      state,
   output logic            ir_so,
   output logic [IR_W-1:0] ir_cur
);

   localparam logic [IR_W-1:0] CAPTURE_VAL = IR_W'(1);
   localparam logic [IR_W-1:0] RESET_VAL   = '1;

   logic [IR_W-1:0] sr;

   always_ff @(posedge tck) begin
      if (state == ST_CAP_IR) begin
         sr <= CAPTURE_VAL;
      end else if (state == ST_SHF_IR) begin
         sr <= {tdi, sr[IR_W-1:1]};
      end
   end

   always_ff @(negedge tck) begin
      if (state == ST_RESET) begin
         ir_cur <= RESET_VAL;
      end else if (state == ST_UPD_IR) begin
         ir_cur <= sr;
      end
   end

   assign ir_so = sr[0];

endmodule

// File: rtl/tap_boundary.sv
module tap_boundary
   import tap_pkg::*;
#(
   parameter int unsigned NUM_PINS = 4,
   localparam int unsigned BSR_LEN = NUM_PINS * CELLS_PER_PIN
) (
   input  logic                tck,
   input  logic                tdi,
   input  logic                cap_en,
   input  logic                shf_en,
   input  logic                upd_en,
   input  logic                extest,
   input  logic [NUM_PINS-1:0] pad_in,
   input  logic [NUM_PINS-1:0] core_out,
   input  logic [NUM_PINS-1:0] core_oe,
   output logic                bsr_so,
   output logic [BSR_LEN-1:0]  upd_q,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe
);

   logic [BSR_LEN-1:0] sr;
   logic [BSR_LEN-1:0] cap_vec;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      localparam int unsigned BASE = i * CELLS_PER_PIN;
      assign cap_vec[BASE]     = pad_in[i];
      assign cap_vec[BASE + 1] = core_out[i];
      assign cap_vec[BASE + 2] = core_oe[i];
      assign pad_out[i] = extest ? upd_q[BASE + 1] : core_out[i];
      assign pad_oe[i]  = extest ? upd_q[BASE + 2] : core_oe[i];
   end

   if (BSR_LEN == 1) begin : g_shift_one
      always_ff @(posedge tck) begin
         if (cap_en)      sr <= cap_vec;
         else if (shf_en) sr <= tdi;
      end
   end else begin : g_shift_many
      always_ff @(posedge tck) begin
         if (cap_en)      sr <= cap_vec;
         else if (shf_en) sr <= {tdi, sr[BSR_LEN-1:1]};
      end
   end

   always_ff @(negedge tck) begin
      if (upd_en) upd_q <= sr;
   end

   assign bsr_so = sr[0];

endmodule

// File: rtl/tap_scan_ctrl.sv
module tap_scan_ctrl
   import tap_pkg::*;
#(
   parameter int unsigned NUM_PINS = 4,
   parameter int unsigned IR_W     = 3
) (
   input  logic                tck,
   input  logic                tms,
   input  logic                tdi,
   output logic                tdo,
   output logic                tdo_oe,
   input  logic [NUM_PINS-1:0] pad_in,
   input  logic [NUM_PINS-1:0] core_out,
   input  logic [NUM_PINS-1:0] core_oe,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe
);

   localparam int unsigned     BSR_LEN   = NUM_PINS * CELLS_PER_PIN;
   localparam logic [IR_W-1:0] OP_EXTEST = '0;
   localparam logic [IR_W-1:0] OP_SAMPLE = IR_W'(1);

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("NUM_PINS must be at least 1");
   end
   if (IR_W < 2) begin : g_bad_ir
      $error("IR_W must be at least 2");
   end

   tap_state_e         fsm_state;
   logic [IR_W-1:0]    ir_cur;
   logic               ir_so;
   logic               bsr_so;
   logic [BSR_LEN-1:0] bsr_upd;
   logic               sel_bsr;
   logic               is_extest;
   logic               byp_q;
   logic               in_shift;

   tap_fsm u_fsm (
      .tck   (tck),
      .tms   (tms),
      .state (fsm_state)
   );

   tap_instr_reg #(.IR_W(IR_W)) u_ir (
      .tck    (tck),
      .tdi    (tdi),
      .state  (fsm_state),
      .ir_so  (ir_so),
      .ir_cur (ir_cur)
   );

   assign is_extest = (ir_cur == OP_EXTEST);
   assign sel_bsr   = is_extest || (ir_cur == OP_SAMPLE);

   tap_boundary #(.NUM_PINS(NUM_PINS)) u_bsr (
      .tck      (tck),
      .tdi      (tdi),
      .cap_en   (sel_bsr && fsm_state == ST_CAP_DR),
      .shf_en   (sel_bsr && fsm_state == ST_SHF_DR),
      .upd_en   (sel_bsr && fsm_state == ST_UPD_DR),
      .extest   (is_extest),
      .pad_in   (pad_in),
      .core_out (core_out),
      .core_oe  (core_oe),
      .bsr_so   (bsr_so),
      .upd_q    (bsr_upd),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

   // One-bit path used by bypass and every unassigned opcode.
   always_ff @(posedge tck) begin
      if (fsm_state == ST_CAP_DR)      byp_q <= 1'b0;
      else if (fsm_state == ST_SHF_DR) byp_q <= tdi;
   end

   assign in_shift = (fsm_state == ST_SHF_IR) || (fsm_state == ST_SHF_DR);

   always_ff @(negedge tck) begin
      tdo_oe <= in_shift;
      if (fsm_state == ST_SHF_IR)      tdo <= ir_so;
      else if (fsm_state == ST_SHF_DR) tdo <= sel_bsr ? bsr_so : byp_q;
   end

endmodule

// File: rtl/tap_scan_chk.sv
module tap_scan_chk
   import tap_pkg::*;
#(
   parameter int unsigned NUM_PINS = 4,
   parameter int unsigned IR_W     = 3,
   localparam int unsigned BSR_LEN = NUM_PINS * CELLS_PER_PIN
) (
   input logic                tck,
   input logic                tms,
   input tap_state_e          state,
   input logic [IR_W-1:0]     ir_cur,
   input logic [BSR_LEN-1:0]  bsr_upd,
   input logic                tdo_oe,
   input logic [NUM_PINS-1:0] core_out,
   input logic [NUM_PINS-1:0] core_oe,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe
);

   logic [2:0] ones   = 3'd0;
   logic       synced = 1'b0;
   logic       armed  = 1'b0;

   always_ff @(posedge tck) begin
      ones <= tms ? ((ones == 3'd7) ? ones : ones + 3'd1) : 3'd0;
      if (state == ST_RESET) synced <= 1'b1;
   end

   always_ff @(negedge tck) begin
      armed <= synced;
   end

   // R1
   reset_seq_chk: assert property (@(posedge tck) disable iff (!armed)
      (ones >= 3'd5) |-> (state == ST_RESET));

   // R1
   reset_ir_chk: assert property (@(negedge tck) disable iff (!armed)
      (state == ST_RESET) |=> (ir_cur == '1));

   // R8
   tdo_oe_chk: assert property (@(posedge tck) disable iff (!armed)
      tdo_oe == (state == ST_SHF_IR || state == ST_SHF_DR));

   // R9
   ir_hold_chk: assert property (@(negedge tck) disable iff (!armed)
      !(state == ST_UPD_IR || state == ST_RESET) |=> $stable(ir_cur));

   // R10
   bsr_hold_chk: assert property (@(negedge tck) disable iff (!armed)
      (state != ST_UPD_DR) |=> $stable(bsr_upd));

   // R6
   pads_core_chk: assert property (@(posedge tck) disable iff (!armed)
      (ir_cur != '0) |-> (pad_out == core_out && pad_oe == core_oe));

endmodule

bind tap_scan_ctrl tap_scan_chk #(.NUM_PINS(NUM_PINS), .IR_W(IR_W)) u_chk (
   .tck      (tck),
   .tms      (tms),
   .state    (fsm_state),
   .ir_cur   (ir_cur),
   .bsr_upd  (bsr_upd),
   .tdo_oe   (tdo_oe),
   .core_out (core_out),
   .core_oe  (core_oe),
   .pad_out  (pad_out),
   .pad_oe   (pad_oe)
);

// File: tb/tap_scan_ctrl_bench.sv
module tap_scan_ctrl_bench;

   localparam int NP  = 2;
   localparam int LEN = 3 * NP;

   logic          tck = 1'b0;
   logic          tms = 1'b1;
   logic          tdi = 1'b0;
   logic          tdo;
   logic          tdo_oe;
   logic [NP-1:0] pad_in   = '0;
   logic [NP-1:0] core_out = '0;
   logic [NP-1:0] core_oe  = '0;
   logic [NP-1:0] pad_out;
   logic [NP-1:0] pad_oe;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   always #5 tck = ~tck;

   tap_scan_ctrl #(.NUM_PINS(NP), .IR_W(3)) u_tap_scan_ctrl (
      .tck      (tck),
      .tms      (tms),
      .tdi      (tdi),
      .tdo      (tdo),
      .tdo_oe   (tdo_oe),
      .pad_in   (pad_in),
      .core_out (core_out),
      .core_oe  (core_oe),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Samples the port state left by the last falling edge, then drives the next bit.
   task automatic tick(input logic m, input logic d, output logic o, output logic e);
      @(negedge tck);
      #2;
      o = tdo;
      e = tdo_oe;
      tms = m;
      tdi = d;
   endtask

   task automatic go_reset();
      logic o, e;
      for (int k = 0; k < 5; k++) tick(1'b1, 1'b0, o, e);
      tick(1'b0, 1'b0, o, e);
   endtask

   task automatic ir_scan(input logic [2:0] op, output logic [2:0] cap);
      logic o, e;
      tick(1'b1, 1'b0, o, e);
      tick(1'b1, 1'b0, o, e);
      tick(1'b0, 1'b0, o, e);
      tick(1'b0, 1'b0, o, e);
      for (int k = 0; k < 3; k++) begin
         tick(k == 2, op[k], o, e);
         cap[k] = o;
         chk(e == 1'b1, "R8 oe in shift-ir", 16'(e), 16'd1);
      end
      tick(1'b1, 1'b0, o, e);
      chk(e == 1'b0, "R8 oe after shift-ir", 16'(e), 16'd0);
      tick(1'b0, 1'b0, o, e);
   endtask

   task automatic dr_scan(input int n, input logic [15:0] din, output logic [15:0] dout);
      logic o, e;
      dout = '0;
      tick(1'b1, 1'b0, o, e);
      chk(e == 1'b0, "R8 oe idle", 16'(e), 16'd0);
      tick(1'b0, 1'b0, o, e);
      tick(1'b0, 1'b0, o, e);
      for (int k = 0; k < n; k++) begin
         tick(k == n - 1, din[k], o, e);
         dout[k] = o;
         chk(e == 1'b1, "R8 oe in shift-dr", 16'(e), 16'd1);
      end
      tick(1'b1, 1'b0, o, e);
      chk(e == 1'b0, "R8 oe after shift-dr", 16'(e), 16'd0);
      tick(1'b0, 1'b0, o, e);
   endtask

   function automatic logic [3:0] pads_from(input logic [LEN-1:0] u);
      logic [3:0] r;
      for (int i = 0; i < NP; i++) begin
         r[i]      = u[3*i+1];
         r[NP + i] = u[3*i+2];
      end
      return r;
   endfunction

   initial begin
      logic [2:0]  cap;
      logic [15:0] dout;
      logic [15:0] expv;
      logic [LEN-1:0] capv;
      logic [3:0]  pexp;

      core_out = 2'b10;
      core_oe  = 2'b01;
      pad_in   = 2'b11;
      go_reset();
      // R1 reset state: output enable low, pads follow core
      chk(tdo_oe == 1'b0, "R1 oe after reset", 16'(tdo_oe), 16'd0);
      chk({pad_oe, pad_out} == {core_oe, core_out}, "R1 pads after reset",
          16'({pad_oe, pad_out}), 16'({core_oe, core_out}));
      // R1 R4: reset leaves bypass selected, one-bit delay with a leading zero
      dr_scan(8, 16'h00B3, dout);
      chk(dout[7:0] == {8'hB3 << 1}, "R1 R4 bypass after reset", dout, 16'({8'hB3 << 1}));

      // R2 R3 R5 R6: sweep all opcodes with varied pin patterns
      for (int op = 0; op < 8; op++) begin
         logic [7:0] din;
         din      = 8'h5A ^ 8'(op * 37);
         pad_in   = 2'(op);
         core_out = 2'(op + 1);
         core_oe  = 2'(op >> 1);
         ir_scan(3'(op), cap);
         chk(cap == 3'b001, "R2 capture-ir pattern", 16'(cap), 16'd1);
         dr_scan(8, 16'(din), dout);
         if (op == 0 || op == 1) begin
            for (int i = 0; i < NP; i++) begin
               capv[3*i]   = pad_in[i];
               capv[3*i+1] = core_out[i];
               capv[3*i+2] = core_oe[i];
            end
            expv = 16'({din[1:0], capv});
            chk(dout[7:0] == expv[7:0], "R5 R3 boundary capture and length", dout, expv);
         end else begin
            expv = 16'({din[6:0], 1'b0});
            chk(dout[7:0] == expv[7:0], "R3 R4 unassigned opcode as bypass", dout, expv);
         end
         if (op == 0) begin
            pexp = pads_from(din[7:2]);
            chk({pad_oe, pad_out} == pexp, "R7 extest drives pads", 16'({pad_oe, pad_out}), 16'(pexp));
         end else begin
            chk({pad_oe, pad_out} == {core_oe, core_out}, "R6 pads follow core",
                16'({pad_oe, pad_out}), 16'({core_oe, core_out}));
         end
      end

      // R7 R10 R1: every preload value for the small configuration
      for (int v = 0; v < (1 << LEN); v++) begin
         core_out = 2'(v + 3);
         core_oe  = 2'(v >> 2);
         go_reset();
         ir_scan(3'b001, cap);
         dr_scan(LEN, 16'(v), dout);
         chk({pad_oe, pad_out} == {core_oe, core_out}, "R6 sample keeps core",
             16'({pad_oe, pad_out}), 16'({core_oe, core_out}));
         ir_scan(3'b000, cap);
         pexp = pads_from(LEN'(v));
         chk({pad_oe, pad_out} == pexp, "R7 preload applied", 16'({pad_oe, pad_out}), 16'(pexp));
         ir_scan(3'b000, cap);
         chk({pad_oe, pad_out} == pexp, "R10 R9 ir scan leaves latches", 16'({pad_oe, pad_out}), 16'(pexp));
         go_reset();
         chk({pad_oe, pad_out} == {core_oe, core_out}, "R1 reset releases pads",
             16'({pad_oe, pad_out}), 16'({core_oe, core_out}));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule